// File: doc/BRIEF.md
# Compact Coprocessor-Condition Branch Resolver

This block resolves the two compact branch forms that test a single coprocessor condition bit. It takes one 32-bit instruction word with its fetch address. It identifies the two branch forms, reads the selected bit from a 32-entry condition-flag register, and works out whether the branch is taken. It also computes the target address and flags any exception. The coprocessor side updates the flag register through a single-bit write port.

These branches have no delay slot. A taken result therefore comes with a squash indication, so the fetch side can drop the instruction that follows. When the coprocessor is disabled, the branch is not taken and an unusable-coprocessor exception is raised instead. All results are registered and appear one cycle after the input, marked by a valid-out strobe.

The result stage is a two-state machine:
- `ST_IDLE`: no result is presented.
- `ST_EMIT`: a registered result is on the outputs.

It has four transitions:
- `T_START` (ST_IDLE to ST_EMIT) fires when `in_valid` is high.
- `T_STREAM` (ST_EMIT to ST_EMIT) fires on another valid input.
- `T_DRAIN` (ST_EMIT to ST_IDLE) fires when no input arrives.
- `T_WAIT` (ST_IDLE to ST_IDLE) fires while inputs stay absent.

Because no state blocks a second branch, branches may arrive in consecutive cycles.

Top module: `ccb_resolver_top`

## Requirements
- R1: The word is split as bits [31:26] major opcode, [25:21] sub-opcode, [20:16] selector, [15:0] offset. A word whose major opcode is not 6'b010000 gives out_taken, out_squash, out_cu_exc and out_ri_exc all 0, with out_valid still 1.
- R2: Sub-opcode 5'b01010 (zero form) is taken when the selected flag is 0. Sub-opcode 5'b01011 (nonzero form) is taken when the selected flag is 1. The selector in bits [20:16] picks flag 0 to 31.
- R3: out_target equals in_pc + 4 + the sign extension of {offset, 1'b0}, computed modulo 2^32 with carry out of bit 31 dropped.
- R4: out_squash is 1 exactly when out_taken is 1.
- R5: For either branch form with cop_enable low, out_cu_exc is 1 and out_taken, out_squash and out_ri_exc are 0.
- R6: A word with major opcode 6'b010000 and any other sub-opcode gives out_ri_exc = 1 and out_taken = out_squash = out_cu_exc = 0, whatever cop_enable is.
- R7: When flag_we is high, flag_wdata is written to flag flag_idx. A branch evaluated in the same cycle sees the old value, and a branch in the next cycle sees the new value.
- R8: Each input cycle with in_valid high produces out_valid = 1 with its results one cycle later. A cycle without in_valid gives out_valid = 0 one cycle later, with out_taken, out_squash and both exception flags at 0.
- R9: Valid inputs in consecutive cycles each produce their own result in consecutive cycles.
- R10: After reset, out_valid is 0 and all 32 flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction word and address are present |
| in_instr | input | 32 | Instruction word |
| in_pc | input | 32 | Address of the instruction word |
| cop_enable | input | 1 | Coprocessor access allowed |
| flag_we | input | 1 | Condition flag write strobe |
| flag_idx | input | 5 | Flag written |
| flag_wdata | input | 1 | Value written |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken |
| out_squash | output | 1 | Discard the following instruction |
| out_target | output | 32 | Branch target address |
| out_cu_exc | output | 1 | Coprocessor unusable exception |
| out_ri_exc | output | 1 | Reserved instruction exception |

## Verification
A flag write and a branch evaluation that reads the same flag can fall in the same cycle. The bench provokes this by writing a flag while a branch that selects that flag is presented. It then repeats the branch in the next cycle. The scoreboard expects the first branch to be judged on the flag value before the write and the second on the value after it.

// File: rtl/ccb_pkg.sv
package ccb_pkg;
    localparam int INSTR_W = 32;
    localparam int MAJ_W   = 6;
    localparam int SUB_W   = 5;
    localparam int SEL_W   = 5;
    localparam int OFF_W   = 16;
    localparam int NUM_FLAGS = 1 << SEL_W;

    typedef enum logic [1:0] {
        BK_NONE = 2'd0,
        BK_EQZ  = 2'd1,
        BK_NEZ  = 2'd2,
        BK_RSVD = 2'd3
    } br_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } res_state_e;

    typedef struct packed {
        logic [MAJ_W-1:0] major;
        logic [SUB_W-1:0] sub;
        logic [SEL_W-1:0] sel;
        logic [OFF_W-1:0] off;
    } word_fields_t;
endpackage

// File: rtl/ccb_decode.sv
module ccb_decode
    import ccb_pkg::*;
#(
    parameter logic [MAJ_W-1:0] MAJOR_OP = 6'b010000,
    parameter logic [SUB_W-1:0] SUB_EQZ  = 5'b01010,
    parameter logic [SUB_W-1:0] SUB_NEZ  = 5'b01011
) (
    input  logic [INSTR_W-1:0] instr,
    output br_kind_e           kind,
    output logic [SEL_W-1:0]   sel,
    output logic [OFF_W-1:0]   off
);
    word_fields_t f;

    always_comb begin
        f    = word_fields_t'(instr);
        sel  = f.sel;
        off  = f.off;
        kind = BK_NONE;
        if (f.major == MAJOR_OP) begin
            if (f.sub == SUB_EQZ)      kind = BK_EQZ;
            else if (f.sub == SUB_NEZ) kind = BK_NEZ;
            else                       kind = BK_RSVD;
        end
    end

    always_comb begin
        p_kind_major_r1: assert ((kind == BK_NONE) == (instr[31:26] != MAJOR_OP))
            else $error("p_kind_major_r1");
    end
endmodule

// File: rtl/ccb_flag_file.sv
module ccb_flag_file
    import ccb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic             wr_data,
    input  logic [SEL_W-1:0] rd_idx,
    output logic             rd_bit
);
    logic [NUM_FLAGS-1:0] flags_q;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flags_q[i] <= 1'b0;
            else if (wr_en && (wr_idx == SEL_W'(i)))
                flags_q[i] <= wr_data;
        end
    end

    assign rd_bit = flags_q[rd_idx];

    p_flag_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags_q[$past(wr_idx)] == $past(wr_data))
        else $error("p_flag_write_r7");

    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags_q))
        else $error("p_flag_hold_r7");
endmodule

// File: rtl/ccb_target.sv
module ccb_target
    import ccb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] disp;

    always_comb begin
        disp   = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
        target = pc + STEP + disp;
    end
endmodule

// File: rtl/ccb_resolver_top.sv
module ccb_resolver_top
    import ccb_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter logic [MAJ_W-1:0] MAJOR_OP = 6'b010000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [INSTR_W-1:0]  in_instr,
    input  logic [ADDR_W-1:0]   in_pc,
    input  logic                cop_enable,
    input  logic                flag_we,
    input  logic [SEL_W-1:0]    flag_idx,
    input  logic                flag_wdata,
    output logic                out_valid,
    output logic                out_taken,
    output logic                out_squash,
    output logic [ADDR_W-1:0]   out_target,
    output logic                out_cu_exc,
    output logic                out_ri_exc
);
    br_kind_e          kind;
    logic [SEL_W-1:0]  sel;
    logic [OFF_W-1:0]  off;
    logic              flag_bit;
    logic [ADDR_W-1:0] target_d;
    logic              is_branch, taken_d, cu_d, ri_d;
    res_state_e        state_q, state_d;

    ccb_decode #(.MAJOR_OP(MAJOR_OP)) u_dec (
        .instr (in_instr),
        .kind  (kind),
        .sel   (sel),
        .off   (off)
    );

    ccb_flag_file u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (flag_we),
        .wr_idx  (flag_idx),
        .wr_data (flag_wdata),
        .rd_idx  (sel),
        .rd_bit  (flag_bit)
    );

    ccb_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc     (in_pc),
        .off    (off),
        .target (target_d)
    );

    always_comb begin
        is_branch = (kind == BK_EQZ) || (kind == BK_NEZ);
        cu_d      = is_branch && !cop_enable;
        ri_d      = (kind == BK_RSVD);
        taken_d   = 1'b0;
        if (is_branch && cop_enable)
            taken_d = (kind == BK_EQZ) ? !flag_bit : flag_bit;
    end

    // Next-state process: T_START, T_STREAM, T_DRAIN, T_WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output process: results captured on entering or staying in ST_EMIT
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_taken  <= 1'b0;
            out_squash <= 1'b0;
            out_target <= '0;
            out_cu_exc <= 1'b0;
            out_ri_exc <= 1'b0;
        end else if (state_d == ST_EMIT) begin
            out_taken  <= taken_d;
            out_squash <= taken_d;
            out_target <= target_d;
            out_cu_exc <= cu_d;
            out_ri_exc <= ri_d;
        end else begin
            out_taken  <= 1'b0;
            out_squash <= 1'b0;
            out_target <= '0;
            out_cu_exc <= 1'b0;
            out_ri_exc <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    p_squash_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_squash == out_taken)
        else $error("p_squash_taken_r4");

    p_cu_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_cu_exc |-> (!out_taken && !out_ri_exc))
        else $error("p_cu_blocks_r5");

    p_ri_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_ri_exc |-> (!out_taken && !out_squash))
        else $error("p_ri_blocks_r6");

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid)
        else $error("p_latency_r8");

    p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid)
        else $error("p_drain_r8");

    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(out_taken || out_squash || out_cu_exc || out_ri_exc))
        else $error("p_quiet_r8");

    p_enable_cu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cop_enable) |=> !out_taken)
        else $error("p_enable_cu_r5");
endmodule

// File: tb/ccb_resolver_top_tb_top.sv
`timescale 1ns/1ps
module ccb_resolver_top_tb_top;
    typedef struct {
        logic        taken;
        logic        squash;
        logic [31:0] target;
        logic        cu;
        logic        ri;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_pc = '0;
    logic        cop_enable = 1'b0;
    logic        flag_we = 1'b0;
    logic [4:0]  flag_idx = '0;
    logic        flag_wdata = 1'b0;
    logic        out_valid, out_taken, out_squash, out_cu_exc, out_ri_exc;
    logic [31:0] out_target;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];
    logic [31:0] model_flags = '0;

    always #4 clk = ~clk;

    ccb_resolver_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_instr(in_instr),
        .in_pc(in_pc), .cop_enable(cop_enable), .flag_we(flag_we),
        .flag_idx(flag_idx), .flag_wdata(flag_wdata), .out_valid(out_valid),
        .out_taken(out_taken), .out_squash(out_squash), .out_target(out_target),
        .out_cu_exc(out_cu_exc), .out_ri_exc(out_ri_exc)
    );

    function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] sub,
                                       input logic [4:0] ct, input logic [15:0] off);
        return {maj, sub, ct, off};
    endfunction

    function automatic exp_t predict(input logic [31:0] w, input logic [31:0] pc,
                                     input logic en, input string req);
        exp_t e;
        logic br;
        logic f;
        f        = model_flags[w[20:16]];
        br       = (w[31:26] == 6'b010000) && (w[25:21] == 5'b01010 || w[25:21] == 5'b01011);
        e.ri     = (w[31:26] == 6'b010000) && !br;
        e.cu     = br && !en;
        e.taken  = br && en && ((w[25:21] == 5'b01010) ? (f == 1'b0) : (f == 1'b1));
        e.squash = e.taken;
        e.target = pc + 32'd4 + {{15{w[15]}}, w[15:0], 1'b0};
        e.req    = req;
        return e;
    endfunction

    task automatic issue(input logic v, input logic [31:0] w, input logic [31:0] pc,
                         input logic en, input logic we, input logic [4:0] widx,
                         input logic wd, input string req);
        @(posedge clk);
        #1;
        in_valid   = v;
        in_instr   = w;
        in_pc      = pc;
        cop_enable = en;
        flag_we    = we;
        flag_idx   = widx;
        flag_wdata = wd;
        if (v) sb_q.push_back(predict(w, pc, en, req));
        if (we) model_flags[widx] = wd;
    endtask

    task automatic idle_check(input string req);
        issue(1'b0, '0, '0, 1'b0, 1'b0, '0, 1'b0, req);
        @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_taken !== 1'b0 || out_squash !== 1'b0) begin
            failures++;
            $display("FAIL %s idle: valid=%b taken=%b squash=%b expected 0 0 0",
                     req, out_valid, out_taken, out_squash);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid === 1'b1) begin
            checks++;
            if (sb_q.size() == 0) begin
                failures++;
                $display("FAIL R8 unexpected result: valid=1 expected 0");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (out_taken !== e.taken || out_squash !== e.squash || out_target !== e.target ||
                    out_cu_exc !== e.cu || out_ri_exc !== e.ri) begin
                    failures++;
                    $display("FAIL %s: taken=%b squash=%b target=%h cu=%b ri=%b expected %b %b %h %b %b",
                             e.req, out_taken, out_squash, out_target, out_cu_exc, out_ri_exc,
                             e.taken, e.squash, e.target, e.cu, e.ri);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        checks++; // R10 reset state
        if (out_valid !== 1'b0 || out_taken !== 1'b0) begin
            failures++;
            $display("FAIL R10 reset: valid=%b taken=%b expected 0 0", out_valid, out_taken);
        end
        // R10 / R2: flags reset to zero, zero form taken
        issue(1, mk(6'b010000, 5'b01010, 5'd3, 16'h0010), 32'h0000_1000, 1, 0, 0, 0, "R10_R2_R3");
        issue(1, mk(6'b010000, 5'b01011, 5'd3, 16'h0010), 32'h0000_1000, 1, 0, 0, 0, "R2_nez_clear");
        // R7: write flag 3 while branch reads it, old value seen; R9 back-to-back
        issue(1, mk(6'b010000, 5'b01011, 5'd3, 16'h0004), 32'h0000_2000, 1, 1, 5'd3, 1, "R7_same_cycle");
        issue(1, mk(6'b010000, 5'b01011, 5'd3, 16'h0004), 32'h0000_2004, 1, 0, 0, 0, "R7_next_R9");
        issue(1, mk(6'b010000, 5'b01010, 5'd3, 16'h0004), 32'h0000_2008, 1, 0, 0, 0, "R2_eqz_set_R4");
        // R2: selector 31, flag written alone
        issue(0, '0, '0, 1, 1, 5'd31, 1, "R7_write_only");
        issue(1, mk(6'b010000, 5'b01011, 5'd31, 16'h0000), 32'h0000_3000, 1, 0, 0, 0, "R2_sel31");
        issue(1, mk(6'b010000, 5'b01011, 5'd30, 16'h0000), 32'h0000_3000, 1, 0, 0, 0, "R2_sel30");
        // R3: wrap and negative offset
        issue(1, mk(6'b010000, 5'b01010, 5'd0, 16'h0010), 32'hFFFF_FFF0, 1, 0, 0, 0, "R3_wrap");
        issue(1, mk(6'b010000, 5'b01010, 5'd0, 16'h8000), 32'h0010_0000, 1, 0, 0, 0, "R3_neg");
        issue(1, mk(6'b010000, 5'b01010, 5'd0, 16'hFFFF), 32'h0000_0000, 1, 0, 0, 0, "R3_minus2");
        // R5: coprocessor disabled
        issue(1, mk(6'b010000, 5'b01010, 5'd0, 16'h0020), 32'h0000_4000, 0, 0, 0, 0, "R5_eqz_off");
        issue(1, mk(6'b010000, 5'b01011, 5'd3, 16'h0020), 32'h0000_4000, 0, 0, 0, 0, "R5_nez_off");
        // R6: reserved sub-opcodes
        issue(1, mk(6'b010000, 5'b00000, 5'd0, 16'h0000), 32'h0000_5000, 1, 0, 0, 0, "R6_sub0");
        issue(1, mk(6'b010000, 5'b01100, 5'd3, 16'h0000), 32'h0000_5000, 0, 0, 0, 0, "R6_dis");
        // R1: other major opcode
        issue(1, mk(6'b010001, 5'b01010, 5'd0, 16'h0000), 32'h0000_6000, 1, 0, 0, 0, "R1_other");
        issue(1, mk(6'b000000, 5'b01011, 5'd3, 16'h0000), 32'h0000_6000, 1, 0, 0, 0, "R1_zero");
        // R8: gap produces no result
        idle_check("R8");
        // R7: clear flag 3 then read
        issue(0, '0, '0, 1, 1, 5'd3, 0, "R7_clear");
        issue(1, mk(6'b010000, 5'b01010, 5'd3, 16'h0002), 32'h0000_7000, 1, 0, 0, 0, "R7_cleared");
        idle_check("R8_drain");
        checks++;
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL R8 missing results: pending=%0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule